// File: doc/BRIEF.md
# Synthesizer Frequency Load Sequencer

This block sits on the host side of a direct digital synthesizer and programs its 32-bit frequency register over a three-wire serial link. A one-cycle start request captures a tuning word. The block then sends six 16-bit commands, most significant bit first. The first command parks the synthesizer: sleep, reset and clear are all set. The next four commands carry the four bytes of the tuning word. They alternate a hold-only code with a commit code, so that each 16-bit half of the register changes in a single update. The last command releases sleep and reset so the output runs.

The serial clock comes from the system clock through a parameterized divider. The clock idles high. Data moves on its rising edge and the receiver captures it on the falling edge. Frame sync goes low for each command. Between commands it goes high for a short gap whose length is a parameter. While a sequence is running, a busy flag is raised. A single-cycle done pulse marks the end of the sequence.

Top module: `dds_freq_prog`

## Requirements
- R1: After reset, sclk_o and fsync_o are high, mosi_o is low, and busy_o and done_o are low.
- R2: The first command of every sequence is 0xF800. In it, D15..D14 = 11 selects the control command, and D13, D12 and D11 set sleep, reset and clear.
- R3: Commands two to five place the opcode in D15..D12, the byte address in D11..D8 and a tuning-word byte in D7..D0. The four commands are, in order: (0x3, 0x3, tw[31:24]), (0x2, 0x2, tw[23:16]), (0x3, 0x1, tw[15:8]) and (0x2, 0x0, tw[7:0]). Opcode 0x3 only holds the byte. Opcode 0x2 commits the held 16 bits.
- R4: The sixth and final command is 0xC000, which clears sleep, reset and clear.
- R5: Each command is one frame. While fsync_o is low, sclk_o has exactly 16 falling edges, and the bits go out MSB first. Outside frames, sclk_o stays high.
- R6: mosi_o changes only when sclk_o rises or when a frame begins. It is stable at every falling edge of sclk_o.
- R7: Between two frames of a sequence, fsync_o stays high for at least two system clocks.
- R8: busy_o rises in the cycle after an accepted start and stays high until done_o. done_o is a one-cycle pulse that comes after the sixth frame, in the same cycle in which busy_o falls.
- R9: A start request made while busy_o is high is ignored. The sequence and its command stream continue unchanged.
- R10: The tuning word is sampled when start is accepted. Later changes on tw_i do not alter the commands in flight.
- R11: Each half period of sclk_o within a frame lasts CLK_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, one cycle |
| tw_i | input | 32 | Frequency tuning word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished, one-cycle pulse |
| sclk_o | output | 1 | Serial clock, idles high |
| fsync_o | output | 1 | Frame sync, active low |
| mosi_o | output | 1 | Serial data, MSB first |

## Verification
The hardest case to reach from the ports is a start request, together with a new tuning word, that arrives in the middle of a frame. It must change neither the captured word nor the state of the sequence. The stimulus waits a fixed number of clocks into a running sequence. It then presents a different tuning word and pulses start. The bench decodes every command from the serial lines and checks that the stream still matches the word captured at the first start. The bench also starts a new sequence on the clock right after done, to test the edge where busy falls.

// File: rtl/dds_seq_pkg.sv
package dds_seq_pkg;
  localparam int unsigned CMD_W     = 16;
  localparam int unsigned TW_W      = 32;
  localparam int unsigned TW_BYTES  = TW_W / 8;
  localparam int unsigned NUM_CMDS  = TW_BYTES + 2;
  localparam int unsigned IDX_W     = $clog2(NUM_CMDS);

  localparam logic [CMD_W-1:0] CMD_PARK    = 16'hF800;
  localparam logic [CMD_W-1:0] CMD_RELEASE = 16'hC000;
  localparam logic [3:0]       OP_HOLD     = 4'h3;
  localparam logic [3:0]       OP_COMMIT   = 4'h2;

  typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_WAIT} seq_state_e;
  typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_GAP} tx_state_e;
endpackage

// File: rtl/dds_cmd_gen.sv
module dds_cmd_gen
  import dds_seq_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TW_W-1:0]  tw_i,
  output logic [CMD_W-1:0] cmd_o
);
  localparam int unsigned LAST = NUM_CMDS - 1;

  logic [CMD_W-1:0] byte_cmd [TW_BYTES];

  // byte k goes out k-th, high byte first; even k holds, odd k commits
  for (genvar k = 0; k < TW_BYTES; k++) begin : g_byte
    localparam logic [3:0] OP   = (k % 2 == 0) ? OP_HOLD : OP_COMMIT;
    localparam logic [3:0] ADDR = 4'(TW_BYTES - 1 - k);
    assign byte_cmd[k] = {OP, ADDR, tw_i[TW_W-1-8*k -: 8]};
  end

  always_comb begin
    cmd_o = CMD_PARK;
    if (idx_i == IDX_W'(LAST)) cmd_o = CMD_RELEASE;
    else if (idx_i != '0)      cmd_o = byte_cmd[idx_i - IDX_W'(1)];
  end
endmodule

// File: rtl/dds_spi_tx.sv
module dds_spi_tx
  import dds_seq_pkg::*;
#(
  parameter int unsigned CLK_DIV = 2,
  parameter int unsigned GAP_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CMD_W-1:0] word_i,
  output logic             word_done_o,
  output logic             sclk_o,
  output logic             fsync_o,
  output logic             mosi_o
);
  localparam int unsigned DIV_W = $clog2(CLK_DIV + 1);
  localparam int unsigned BIT_W = $clog2(CMD_W + 1);
  localparam int unsigned GAP_W = $clog2(GAP_CYC + 1);

  tx_state_e        st_q;
  logic [CMD_W-1:0] sr_q;
  logic [DIV_W-1:0] div_q;
  logic [BIT_W-1:0] bit_q;
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= TX_IDLE;
      sr_q        <= '0;
      div_q       <= '0;
      bit_q       <= '0;
      gap_q       <= '0;
      sclk_o      <= 1'b1;
      fsync_o     <= 1'b1;
      word_done_o <= 1'b0;
    end else begin
      word_done_o <= 1'b0;
      unique case (st_q)
        TX_IDLE: if (load_i) begin
          sr_q    <= word_i;
          fsync_o <= 1'b0;
          div_q   <= '0;
          bit_q   <= '0;
          st_q    <= TX_SHIFT;
        end
        TX_SHIFT: begin
          if (div_q == DIV_W'(CLK_DIV - 1)) begin
            div_q  <= '0;
            sclk_o <= ~sclk_o;
            // rising edge: advance to next bit or close frame
            if (!sclk_o) begin
              if (bit_q == BIT_W'(CMD_W - 1)) begin
                fsync_o <= 1'b1;
                gap_q   <= '0;
                st_q    <= TX_GAP;
              end else begin
                sr_q  <= {sr_q[CMD_W-2:0], 1'b0};
                bit_q <= bit_q + BIT_W'(1);
              end
            end
          end else begin
            div_q <= div_q + DIV_W'(1);
          end
        end
        TX_GAP: begin
          if (gap_q == GAP_W'(GAP_CYC - 1)) begin
            word_done_o <= 1'b1;
            st_q        <= TX_IDLE;
          end else begin
            gap_q <= gap_q + GAP_W'(1);
          end
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  assign mosi_o = ~fsync_o & sr_q[CMD_W-1];
endmodule

// File: rtl/dds_seq_ctrl.sv
module dds_seq_ctrl
  import dds_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TW_W-1:0]  tw_i,
  input  logic             tx_done_i,
  output logic             load_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [TW_W-1:0]  tw_o,
  output logic             busy_o,
  output logic             done_o
);
  seq_state_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_IDLE;
      idx_o  <= '0;
      tw_o   <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        SQ_IDLE: if (start_i) begin
          tw_o   <= tw_i;
          idx_o  <= '0;
          busy_o <= 1'b1;
          st_q   <= SQ_LOAD;
        end
        SQ_LOAD: st_q <= SQ_WAIT;
        SQ_WAIT: if (tx_done_i) begin
          if (idx_o == IDX_W'(NUM_CMDS - 1)) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
            st_q   <= SQ_IDLE;
          end else begin
            idx_o <= idx_o + IDX_W'(1);
            st_q  <= SQ_LOAD;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign load_o = (st_q == SQ_LOAD);
endmodule

// File: rtl/dds_freq_prog.sv
module dds_freq_prog
  import dds_seq_pkg::*;
#(
  parameter int unsigned CLK_DIV = 2,
  parameter int unsigned GAP_CYC = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [31:0] tw_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        sclk_o,
  output logic        fsync_o,
  output logic        mosi_o
);
  logic             load;
  logic             tx_done;
  logic [IDX_W-1:0] idx;
  logic [TW_W-1:0]  tw_q;
  logic [CMD_W-1:0] cmd;

  dds_seq_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i, .tw_i,
    .tx_done_i (tx_done),
    .load_o    (load),
    .idx_o     (idx),
    .tw_o      (tw_q),
    .busy_o, .done_o
  );

  dds_cmd_gen u_gen (.idx_i(idx), .tw_i(tw_q), .cmd_o(cmd));

  dds_spi_tx #(.CLK_DIV(CLK_DIV), .GAP_CYC(GAP_CYC)) u_tx (
    .clk_i, .rst_ni,
    .load_i      (load),
    .word_i      (cmd),
    .word_done_o (tx_done),
    .sclk_o, .fsync_o, .mosi_o
  );
endmodule

// File: rtl/dds_freq_prog_chk.sv
module dds_freq_prog_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [31:0] tw_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        sclk_o,
  input logic        fsync_o,
  input logic        mosi_o
);
  logic       sclk_q;
  logic [4:0] fall_cnt;
  logic [3:0] frame_cnt;
  logic       fsync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b1;
      fsync_q   <= 1'b1;
      fall_cnt  <= '0;
      frame_cnt <= '0;
    end else begin
      sclk_q  <= sclk_o;
      fsync_q <= fsync_o;
      if (fsync_o)              fall_cnt <= '0;
      else if (sclk_q && !sclk_o) fall_cnt <= fall_cnt + 5'd1;
      if (!busy_o && start_i)       frame_cnt <= '0;
      else if (fsync_o && !fsync_q) frame_cnt <= frame_cnt + 4'd1;
    end
  end

  a_r5_sixteen_falls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsync_o && !fsync_q) |-> fall_cnt == 5'd16);
  a_r5_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (fsync_o && sclk_o));
  a_r6_mosi_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_q && !sclk_o && !fsync_o) |-> $stable(mosi_o));
  a_r7_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsync_o && !fsync_q) |=> fsync_o);
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  a_r8_six_frames: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> frame_cnt == 4'd6);
  a_r9_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && !fsync_q) |=> busy_o);
endmodule

bind dds_freq_prog dds_freq_prog_chk u_chk (.*);

// File: tb/tb_dds_freq_prog.sv
module tb_dds_freq_prog;
  localparam int DIV = 3;
  localparam int GAP = 2;
  localparam int WD  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] tw = '0;
  logic        busy, done, sclk, fsync, mosi;

  int compared = 0, mismatched = 0, cyc = 0, done_cnt = 0, seq_cnt = 0;
  logic [15:0] exp_q[$];
  bit   exp_busy = 0;
  logic prev_sclk = 1'b1, prev_fsync = 1'b1, prev_mosi = 1'b0;
  int   half_cnt = 0, rx_bits = 0, gap_cnt = 0, words_rx = 0;
  logic [15:0] rx_word = '0;
  bit   seen_frame = 0;

  always #4 clk = ~clk;

  dds_freq_prog #(.CLK_DIV(DIV), .GAP_CYC(GAP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tw_i(tw),
    .busy_o(busy), .done_o(done), .sclk_o(sclk), .fsync_o(fsync), .mosi_o(mosi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] model_word(input logic [31:0] w, input int i);
    case (i)
      0: return 16'hF800;
      1: return {8'h33, w[31:24]};
      2: return {8'h22, w[23:16]};
      3: return {8'h31, w[15:8]};
      4: return {8'h20, w[7:0]};
      default: return 16'hC000;
    endcase
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // reference model, evaluated just after each rising edge
  always @(posedge clk) begin
    #2;
    cyc++;
    if (cyc > WD) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
    if (rst_n) begin
      if (start && !exp_busy) begin
        exp_busy = 1;
        exp_q.delete();
        for (int i = 0; i < 6; i++) exp_q.push_back(model_word(tw, i));
        words_rx = 0; seen_frame = 0;
      end
      if (done) begin
        chk("R8 words before done", words_rx, 6);
        done_cnt++;
        exp_busy = 0;
      end
      chk("R8 busy", busy, exp_busy);
      if (!fsync) begin
        if (prev_fsync) begin
          if (seen_frame) chk("R7 gap>=2", gap_cnt >= GAP, 1);
          chk("R5 sclk high at frame start", sclk, 1'b1);
          rx_bits = 0; half_cnt = 0;
        end else begin
          half_cnt++;
          if (sclk != prev_sclk) begin
            chk("R11 half period", half_cnt, DIV);
            half_cnt = 0;
            if (!sclk) begin
              chk("R6 mosi stable at fall", mosi, prev_mosi);
              rx_word = {rx_word[14:0], mosi};
              rx_bits++;
            end
          end
        end
      end else if (!prev_fsync) begin
        chk("R5 bits per frame", rx_bits, 16);
        if (exp_q.size() == 0) chk("R9 extra frame", 1, 0);
        else chk(words_rx == 0 ? "R2 park word" : words_rx == 5 ? "R4 release word" : "R3 byte word",
                 rx_word, exp_q.pop_front());
        words_rx++; seen_frame = 1; gap_cnt = 1;
      end else begin
        gap_cnt++;
        if (!busy) chk("R5 sclk idle", sclk, 1'b1);
      end
      prev_sclk = sclk; prev_fsync = fsync; prev_mosi = mosi;
    end
  end

  task automatic pulse_start(input logic [31:0] w);
    @(negedge clk); tw = w; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sclk", sclk, 1'b1);
    chk("R1 fsync", fsync, 1'b1);
    chk("R1 mosi", mosi, 1'b0);
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    pulse_start(32'h3333_3333); seq_cnt++; wait_done();
    repeat (4) @(negedge clk);

    // R9 and R10: restart and word change mid-frame are ignored
    pulse_start(32'h1234_5678); seq_cnt++;
    repeat (40) @(negedge clk);
    tw = 32'hAAAA_5555; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (150) @(negedge clk);
    tw = 32'h0F0F_F0F0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();

    // back-to-back start right after done
    pulse_start(32'h0000_0000); seq_cnt++; wait_done();
    @(negedge clk); tw = 32'hFFFF_FFFF; start = 1'b1;
    @(negedge clk); start = 1'b0; seq_cnt++;
    wait_done();
    pulse_start(32'hDEAD_BEEF); seq_cnt++; wait_done();
    repeat (6) @(negedge clk);

    chk("R8 done count", done_cnt, seq_cnt);
    chk("R9 no pending words", exp_q.size(), 0);
    chk("R8 idle busy", busy, 1'b0);
    finish_run();
  end
endmodule